// File: doc/BRIEF.md
# Serial Management Bus Keyhole Master

This block lets several software agents start single read or write transactions on a shared serial management bus. Each agent owns one of four register windows ("keyholes"). A window holds a control/status word, a write-data word, a mutex word and a read-data word. Software loads the write-data word, then writes the control word with the start bit set, the direction, a bus number and a device/register address.

Pending windows are served one at a time by a single transaction engine. A round-robin arbiter picks the next window. The engine drives a request/acknowledge port toward the slaves and ends each transaction in one of three ways: a clean acknowledge, an acknowledge flagged as a slave error, or a timeout. A global timeout register sets the timeout length. The mutex word lets cooperating agents claim a window before they use it.

The register address is `{tmo_sel, set[1:0], word[1:0]}`. When the top address bit is 1, the access goes to the timeout register. Otherwise it goes to word `word` of window `set`: 0 is control/status, 1 is write data, 2 is mutex and 3 is read data.

Top module: `mkm_keyhole_master`

## Requirements
- R1: After reset, every window word reads 0, the timeout register reads 20 and `req_valid_o` is 0.
- R2: Control word bit layout: bit 31 start, bit 30 timeout flag, bit 29 slave-error flag, bit 28 busy, bit 24 direction (1 = write, 0 = read), bits 23:20 bus number, bits 15:0 device address, all other bits 0. A control write with bit 31 set to an idle window starts a transaction. From the next cycle until completion, bits 31 and 28 both read 1, and both read 0 once the transaction is over.
- R3: While a window's start bit is 1, writes to its control word and its write-data word are ignored. The write-data word reads back the value last written while the window was idle.
- R4: A read transaction that is acknowledged loads `ack_rdata_i` into the read-data word at the acknowledge edge, the same edge at which busy falls. Writes to the read-data word are ignored.
- R5: An acknowledge with `ack_err_i` = 1 sets the slave-error flag (bit 29) and leaves the timeout flag at 0.
- R6: If no acknowledge arrives within timeout+1 request cycles, the request drops, the timeout flag (bit 30) is set, and the read-data word is left unchanged.
- R7: Starting a new transaction clears both status flags of that window.
- R8: The timeout register is read and written at any address whose top bit is 1. Its reset value is 20.
- R9: `req_valid_o` rises two cycles after the starting control write. While it is high, the direction, bus, address and write data stay stable. It falls in the cycle after the acknowledge.
- R10: When several windows are pending, they are granted one at a time in round-robin order, starting from the window after the last one granted. After reset, that starting window is window 0.
- R11: A read of a mutex word returns its lock bit (0 = free) and then sets it, so later reads return 1. A write of 0 releases the lock. A write of a non-zero value has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (has side effects on mutex words) |
| reg_addr_i | input | 5 | Register address {tmo_sel, set, word} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| req_valid_o | output | 1 | Transaction request toward slaves |
| req_write_o | output | 1 | Request direction, 1 = write |
| req_bus_o | output | 4 | Bus number of the request |
| req_addr_o | output | 16 | Device/register address of the request |
| req_wdata_o | output | 32 | Write data of the request |
| ack_i | input | 1 | Slave acknowledge |
| ack_err_i | input | 1 | Slave error, qualified by ack_i |
| ack_rdata_i | input | 32 | Slave read data, qualified by ack_i |

## Verification
A control write at the edge ending cycle N makes busy visible in cycle N+1 and raises the request in cycle N+2. An acknowledge seen in cycle K makes the request low and the status and read data final in cycle K+1. A timeout ends a request after timeout+1 cycles. The bench keeps a behavioural model that advances at each rising edge. It drives inputs at the falling edge, samples the outputs 1 ns later and compares them with the model every cycle, so each result is checked in exactly the cycle it is due. Directed hand-computed values cover the status encodings, the arbitration order and the mutex sequence.

// File: rtl/mkm_pkg.sv
package mkm_pkg;
    localparam int CTRL_START   = 31;
    localparam int CTRL_TMO     = 30;
    localparam int CTRL_ERR     = 29;
    localparam int CTRL_BUSY    = 28;
    localparam int CTRL_DIR     = 24;
    localparam int CTRL_BUS_LSB = 20;

    typedef enum logic [1:0] {
        W_CTRL  = 2'd0,
        W_WDATA = 2'd1,
        W_MUTEX = 2'd2,
        W_RDATA = 2'd3
    } word_e;
endpackage

// File: rtl/mkm_keyhole.sv
module mkm_keyhole
    import mkm_pkg::*;
#(
    parameter int BUS_W  = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_wr_i,
    input  logic              sel_rd_i,
    input  logic [1:0]        word_i,
    input  logic [31:0]       wdata_i,
    input  logic              done_i,
    input  logic              done_tmo_i,
    input  logic              done_err_i,
    input  logic              done_load_i,
    input  logic [31:0]       done_rdata_i,
    output logic [31:0]       rdata_o,
    output logic              start_o,
    output logic              dir_o,
    output logic [BUS_W-1:0]  bus_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [31:0]       wd_o
);
    typedef struct packed {
        logic              start;
        logic              tmo;
        logic              err;
        logic              dir;
        logic              lock;
        logic [BUS_W-1:0]  bus;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wd;
        logic [31:0]       rd;
    } kh_t;

    kh_t kh_d, kh_q;
    logic [31:0] ctrl_word;

    always_comb begin
        kh_d = kh_q;
        if (sel_wr_i) begin
            case (word_e'(word_i))
                W_CTRL: begin
                    if (!kh_q.start && wdata_i[CTRL_START]) begin
                        kh_d.start = 1'b1;
                        kh_d.tmo   = 1'b0;
                        kh_d.err   = 1'b0;
                        kh_d.dir   = wdata_i[CTRL_DIR];
                        kh_d.bus   = wdata_i[CTRL_BUS_LSB +: BUS_W];
                        kh_d.addr  = wdata_i[ADDR_W-1:0];
                    end
                end
                W_WDATA: if (!kh_q.start) kh_d.wd = wdata_i;
                W_MUTEX: if (wdata_i == 32'd0) kh_d.lock = 1'b0;
                default: ;
            endcase
        end
        if (sel_rd_i && (word_e'(word_i) == W_MUTEX)) kh_d.lock = 1'b1;
        if (done_i) begin
            kh_d.start = 1'b0;
            kh_d.tmo   = done_tmo_i;
            kh_d.err   = done_err_i;
            if (done_load_i) kh_d.rd = done_rdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) kh_q <= '0;
        else         kh_q <= kh_d;
    end

    always_comb begin
        ctrl_word                            = '0;
        ctrl_word[CTRL_START]                = kh_q.start;
        ctrl_word[CTRL_TMO]                  = kh_q.tmo;
        ctrl_word[CTRL_ERR]                  = kh_q.err;
        ctrl_word[CTRL_BUSY]                 = kh_q.start;
        ctrl_word[CTRL_DIR]                  = kh_q.dir;
        ctrl_word[CTRL_BUS_LSB +: BUS_W]     = kh_q.bus;
        ctrl_word[ADDR_W-1:0]                = kh_q.addr;
        case (word_e'(word_i))
            W_CTRL:  rdata_o = ctrl_word;
            W_WDATA: rdata_o = kh_q.wd;
            W_MUTEX: rdata_o = {31'd0, kh_q.lock};
            default: rdata_o = kh_q.rd;
        endcase
    end

    assign start_o = kh_q.start;
    assign dir_o   = kh_q.dir;
    assign bus_o   = kh_q.bus;
    assign addr_o  = kh_q.addr;
    assign wd_o    = kh_q.wd;
endmodule

// File: rtl/mkm_rr_arb.sv
module mkm_rr_arb #(
    parameter  int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [N-1:0]  req_i,
    input  logic          take_i,
    output logic          any_o,
    output logic [IW-1:0] pick_o
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        any_o  = 1'b0;
        pick_o = '0;
        for (int i = N - 1; i >= 0; i--) begin : scan
            int j;
            j = int'(arb_q.ptr) + i;
            if (j >= N) j = j - N;
            if (req_i[j]) begin
                any_o  = 1'b1;
                pick_o = IW'(j);
            end
        end
        arb_d = arb_q;
        if (take_i && any_o)
            arb_d.ptr = (int'(pick_o) == N - 1) ? '0 : pick_o + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) arb_q <= '0;
        else         arb_q <= arb_d;
    end
endmodule

// File: rtl/mkm_tmo_timer.sv
module mkm_tmo_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.cnt = run_i ? tmr_q.cnt + 1'b1 : '0;
        expired_o = run_i && (tmr_q.cnt >= limit_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end
endmodule

// File: rtl/mkm_keyhole_master.sv
module mkm_keyhole_master
    import mkm_pkg::*;
#(
    parameter  int NUM_SETS = 4,
    parameter  int BUS_W    = 4,
    parameter  int DEV_AW   = 16,
    parameter  int TMO_W    = 16,
    parameter  int TMO_INIT = 20,
    localparam int IW       = $clog2(NUM_SETS),
    localparam int REG_AW   = IW + 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic [BUS_W-1:0]  req_bus_o,
    output logic [DEV_AW-1:0] req_addr_o,
    output logic [31:0]       req_wdata_o,
    input  logic              ack_i,
    input  logic              ack_err_i,
    input  logic [31:0]       ack_rdata_i
);
    typedef struct packed {
        logic             active;
        logic [IW-1:0]    idx;
        logic [TMO_W-1:0] tmo;
    } eng_t;

    eng_t eng_d, eng_q;

    logic              tmo_sel;
    logic [IW-1:0]     set_idx;
    logic [1:0]        word;
    logic [NUM_SETS-1:0] start_vec;
    logic [NUM_SETS-1:0] done_vec;
    logic [31:0]       kh_rdata [NUM_SETS];
    logic              kh_dir   [NUM_SETS];
    logic [BUS_W-1:0]  kh_bus   [NUM_SETS];
    logic [DEV_AW-1:0] kh_addr  [NUM_SETS];
    logic [31:0]       kh_wd    [NUM_SETS];
    logic              arb_any;
    logic [IW-1:0]     arb_pick;
    logic              expired;
    logic              finish;
    logic [TMO_W-1:0]  tmo_val;

    assign tmo_sel = reg_addr_i[REG_AW-1];
    assign set_idx = reg_addr_i[IW+1:2];
    assign word    = reg_addr_i[1:0];
    assign finish  = eng_q.active && (ack_i || expired);
    assign tmo_val = eng_q.tmo;

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        assign done_vec[g] = finish && (eng_q.idx == IW'(g));
        mkm_keyhole #(.BUS_W(BUS_W), .ADDR_W(DEV_AW)) u_kh (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .sel_wr_i     (reg_wr_i && !tmo_sel && (set_idx == IW'(g))),
            .sel_rd_i     (reg_rd_i && !tmo_sel && (set_idx == IW'(g))),
            .word_i       (word),
            .wdata_i      (reg_wdata_i),
            .done_i       (done_vec[g]),
            .done_tmo_i   (!ack_i),
            .done_err_i   (ack_i && ack_err_i),
            .done_load_i  (ack_i && !kh_dir[g]),
            .done_rdata_i (ack_rdata_i),
            .rdata_o      (kh_rdata[g]),
            .start_o      (start_vec[g]),
            .dir_o        (kh_dir[g]),
            .bus_o        (kh_bus[g]),
            .addr_o       (kh_addr[g]),
            .wd_o         (kh_wd[g])
        );
    end

    mkm_rr_arb #(.N(NUM_SETS)) u_arb (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (start_vec),
        .take_i (!eng_q.active),
        .any_o  (arb_any),
        .pick_o (arb_pick)
    );

    mkm_tmo_timer #(.W(TMO_W)) u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (eng_q.active),
        .limit_i   (eng_q.tmo),
        .expired_o (expired)
    );

    always_comb begin
        eng_d = eng_q;
        if (finish) begin
            eng_d.active = 1'b0;
        end else if (!eng_q.active && arb_any) begin
            eng_d.active = 1'b1;
            eng_d.idx    = arb_pick;
        end
        if (reg_wr_i && tmo_sel) eng_d.tmo = reg_wdata_i[TMO_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q     <= '0;
            eng_q.tmo <= TMO_W'(TMO_INIT);
        end else begin
            eng_q <= eng_d;
        end
    end

    assign reg_rdata_o = tmo_sel ? 32'(eng_q.tmo) : kh_rdata[set_idx];
    assign req_valid_o = eng_q.active;
    assign req_write_o = kh_dir[eng_q.idx];
    assign req_bus_o   = kh_bus[eng_q.idx];
    assign req_addr_o  = kh_addr[eng_q.idx];
    assign req_wdata_o = kh_wd[eng_q.idx];
endmodule

// File: rtl/mkm_keyhole_master_chk.sv
module mkm_keyhole_master_chk #(
    parameter int NUM_SETS = 4,
    parameter int BUS_W    = 4,
    parameter int DEV_AW   = 16,
    parameter int TMO_W    = 16
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                req_valid_i,
    input logic                req_write_i,
    input logic [BUS_W-1:0]    req_bus_i,
    input logic [DEV_AW-1:0]   req_addr_i,
    input logic [31:0]         req_wdata_i,
    input logic                ack_i,
    input logic [TMO_W-1:0]    tmo_i,
    input logic [NUM_SETS-1:0] done_i,
    input logic [NUM_SETS-1:0] start_i
);
    logic [31:0] win_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          win_cnt <= '0;
        else if (req_valid_i) win_cnt <= win_cnt + 1;
        else                  win_cnt <= '0;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && !ack_i |=> !req_valid_i ||
            ($stable(req_write_i) && $stable(req_bus_i) &&
             $stable(req_addr_i) && $stable(req_wdata_i)));

    // R9
    req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && ack_i |=> !req_valid_i);

    // R6
    req_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |-> win_cnt <= 32'(tmo_i));

    // R6
    tmo_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && !ack_i && (win_cnt == 32'(tmo_i)) |=> !req_valid_i);

    // R10
    one_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(done_i));

    // R2
    req_has_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |-> (start_i != '0));
endmodule

bind mkm_keyhole_master mkm_keyhole_master_chk #(
    .NUM_SETS (NUM_SETS),
    .BUS_W    (BUS_W),
    .DEV_AW   (DEV_AW),
    .TMO_W    (TMO_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_o),
    .req_write_i (req_write_o),
    .req_bus_i   (req_bus_o),
    .req_addr_i  (req_addr_o),
    .req_wdata_i (req_wdata_o),
    .ack_i       (ack_i),
    .tmo_i       (tmo_val),
    .done_i      (done_vec),
    .start_i     (start_vec)
);

// File: tb/test_mkm_keyhole_master.sv
module test_mkm_keyhole_master;
    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [4:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        req_valid_o;
    logic        req_write_o;
    logic [3:0]  req_bus_o;
    logic [15:0] req_addr_o;
    logic [31:0] req_wdata_o;
    logic        ack_i = 1'b0;
    logic        ack_err_i = 1'b0;
    logic [31:0] ack_rdata_i = '0;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    bit          m_start [4];
    bit          m_tf [4];
    bit          m_ef [4];
    bit          m_dir [4];
    bit          m_lock [4];
    bit [3:0]    m_bus [4];
    bit [15:0]   m_addr [4];
    bit [31:0]   m_wd [4];
    bit [31:0]   m_rd [4];
    int          m_tmo = 20;
    int          m_rr = 0;
    bit          m_act = 0;
    int          m_idx = 0;
    int          m_cnt = 0;
    // slave behaviour
    int          s_cnt = 0;
    int          s_delay = 0;
    bit          s_err = 0;
    bit [31:0]   s_data = '0;
    bit          prev_valid = 0;
    bit [15:0]   grant_log [$];

    mkm_keyhole_master i_mkm_keyhole_master (.*);

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    task automatic expect32(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic bit [31:0] exp_read(int a);
        int s = (a >> 2) & 3;
        if (a[4]) return 32'(m_tmo);
        case (a & 3)
            0: return {m_start[s], m_tf[s], m_ef[s], m_start[s], 3'b000, m_dir[s],
                       m_bus[s], 4'h0, m_addr[s]};
            1: return m_wd[s];
            2: return {31'd0, m_lock[s]};
            default: return m_rd[s];
        endcase
    endfunction

    function automatic string word_tag(int a);
        if (a[4]) return "R8";
        case (a & 3)
            0: return "R2";
            1: return "R3";
            2: return "R11";
            default: return "R4";
        endcase
    endfunction

    task automatic cyc(bit w, bit r, int a, bit [31:0] d);
        int  g;
        bit  fin;
        bit  ack_b;
        int  s;
        @(negedge clk_i);
        reg_wr_i    = w;
        reg_rd_i    = r;
        reg_addr_i  = a[4:0];
        reg_wdata_i = d;
        ack_b       = m_act && (s_cnt == s_delay);
        ack_i       = ack_b;
        ack_err_i   = s_err;
        ack_rdata_i = s_data;
        #1;
        expect32("R9 req_valid", 32'(req_valid_o), 32'(m_act));
        if (m_act) begin
            expect32("R9 req_write", 32'(req_write_o), 32'(m_dir[m_idx]));
            expect32("R9 req_bus", 32'(req_bus_o), 32'(m_bus[m_idx]));
            expect32("R9 req_addr", 32'(req_addr_o), 32'(m_addr[m_idx]));
            expect32("R9 req_wdata", req_wdata_o, m_wd[m_idx]);
        end
        if (req_valid_o && !prev_valid) grant_log.push_back(req_addr_o);
        prev_valid = req_valid_o;
        if (r) expect32(word_tag(a), reg_rdata_o, exp_read(a));
        @(posedge clk_i);
        // reference update: decisions from the state before this edge
        fin = m_act && (ack_b || m_cnt >= m_tmo);
        g = -1;
        if (!m_act)
            for (int i = 0; i < 4; i++)
                if (g < 0 && m_start[(m_rr + i) % 4]) g = (m_rr + i) % 4;
        s = (a >> 2) & 3;
        if (w && a[4]) m_tmo = int'(d[15:0]);
        if (w && !a[4]) begin
            case (a & 3)
                0: if (!m_start[s] && d[31]) begin
                    m_start[s] = 1; m_tf[s] = 0; m_ef[s] = 0;
                    m_dir[s] = d[24]; m_bus[s] = d[23:20]; m_addr[s] = d[15:0];
                end
                1: if (!m_start[s]) m_wd[s] = d;
                2: if (d == 0) m_lock[s] = 0;
                default: ;
            endcase
        end
        if (r && !a[4] && (a & 3) == 2) m_lock[s] = 1;
        if (fin) begin
            m_start[m_idx] = 0;
            m_tf[m_idx] = !ack_b;
            m_ef[m_idx] = ack_b && s_err;
            if (ack_b && !m_dir[m_idx]) m_rd[m_idx] = s_data;
            m_act = 0;
        end else if (m_act) begin
            m_cnt++;
            s_cnt++;
        end else if (g >= 0) begin
            m_act = 1; m_idx = g; m_cnt = 0; s_cnt = 0; m_rr = (g + 1) % 4;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    task automatic wr(int a, bit [31:0] d);
        cyc(1, 0, a, d);
    endtask

    task automatic rd(int a);
        cyc(0, 1, a, 0);
    endtask

    task automatic rd_lit(int a, bit [31:0] exp, string tag);
        rd(a);
        expect32(tag, reg_rdata_o, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;

        // R1 reset state
        rd_lit(0, 32'h0, "R1 ctrl0");
        rd_lit(7, 32'h0, "R1 rdata1");
        rd_lit(16, 32'd20, "R1 R8 timeout reset");
        wr(16, 32'd8);
        rd_lit(16, 32'd8, "R8 timeout write");

        // R2 R3 write transaction on window 0
        s_delay = 2; s_err = 0; s_data = 32'h0BAD_F00D;
        wr(1, 32'hCAFE_0001);
        wr(0, 32'h8130_0042);
        rd_lit(0, 32'h9130_0042, "R2 busy");
        wr(1, 32'h1111_1111);
        wr(0, 32'h8000_0055);
        idle(6);
        rd_lit(1, 32'hCAFE_0001, "R3 wdata kept");
        rd_lit(0, 32'h0130_0042, "R2 done");

        // R4 read transaction on window 1
        s_delay = 1; s_data = 32'hA5A5_5A5A;
        wr(4, 32'h8020_0007);
        idle(5);
        rd_lit(7, 32'hA5A5_5A5A, "R4 rdata");
        wr(7, 32'h0);
        rd_lit(7, 32'hA5A5_5A5A, "R4 rdata write ignored");

        // R5 slave error on window 2
        s_delay = 0; s_err = 1;
        wr(8, 32'h8100_0010);
        idle(4);
        rd_lit(8, 32'h2100_0010, "R5 slave error");

        // R6 timeout on window 3
        s_delay = 1000; s_err = 0; s_data = 32'h7777_7777;
        wr(12, 32'h8010_0020);
        idle(14);
        rd_lit(12, 32'h4010_0020, "R6 timeout flag");
        rd_lit(15, 32'h0, "R6 rdata unchanged");

        // R7 restart clears flags
        s_delay = 0;
        wr(12, 32'h8010_0020);
        idle(4);
        rd_lit(12, 32'h0010_0020, "R7 flags cleared");
        rd_lit(15, 32'h7777_7777, "R7 R4 rdata");

        // R10 round robin: 1 first, then 2, 3, 0
        grant_log.delete();
        s_delay = 3;
        wr(4, 32'h8000_0101);
        wr(0, 32'h8000_0100);
        wr(12, 32'h8000_0103);
        wr(8, 32'h8000_0102);
        idle(30);
        expect32("R10 grants", 32'(grant_log.size()), 32'd4);
        if (grant_log.size() == 4) begin
            expect32("R10 first", 32'(grant_log[0]), 32'h101);
            expect32("R10 second", 32'(grant_log[1]), 32'h102);
            expect32("R10 third", 32'(grant_log[2]), 32'h103);
            expect32("R10 fourth", 32'(grant_log[3]), 32'h100);
        end

        // R11 mutex
        rd_lit(10, 32'h0, "R11 free");
        rd_lit(10, 32'h1, "R11 locked");
        wr(10, 32'h5);
        rd_lit(10, 32'h1, "R11 nonzero write ignored");
        wr(10, 32'h0);
        rd_lit(10, 32'h0, "R11 released");
        rd_lit(10, 32'h1, "R11 relocked");
        rd_lit(2, 32'h0, "R11 other window free");
        idle(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule